// File: doc/BRIEF.md
# Threshold-Monitored Data FIFO with DMA Request

This block is a circular buffer of 16-bit words placed between a processor data port and a memory-card data path. Words enter from either side and leave from either side. In a receive transfer the card side fills the buffer and the processor side drains it. In a transmit transfer the roles are reversed. The block watches the fill level against two programmable thresholds: a high-water level for receive and a low-water level for transmit.

When a threshold condition holds, the block signals it in one of two ways. If DMA is enabled for that direction, it raises a DMA request line. Otherwise it raises a status flag that an interrupt or polling path can observe. The threshold conditions only count for the current transfer direction. When no transfer is running and the buffer is empty, every request line and status flag is low.

All data interfaces use valid/ready. A beat moves on a clock edge only when both valid and ready are high. A processor write offered while the buffer is full is not accepted, and the word is dropped. A processor read is a request: if the buffer is empty it returns the head word and changes no state. The processor side has priority over the card side in both directions. While the processor pushes, the card push port is not ready. While the processor pops, the card pop port is not valid.

Top module: `thresh_fifo_dma`

## Requirements
- R1: Words leave in the order they were accepted; the buffer holds DEPTH (default 32) words, and its pointers wrap modulo DEPTH. The head word is always presented on both read-data outputs.
- R2: `cpu_push_ready` is high exactly when fewer than DEPTH words are held. A word offered while the buffer is full is discarded, and the stored contents and count are unchanged.
- R3: A processor pop request while the buffer is empty moves no pointer and leaves the count at zero. `card_pop_valid` is low while the buffer is empty.
- R4: A push and a pop accepted in the same cycle leave the count unchanged and advance both pointers.
- R5: The configuration register reads back the following fields. Bit 15 is the receive DMA enable, bits 12:8 the high-water level, bit 7 the transmit DMA enable, and bits 4:0 the low-water level. All other bits read zero. After reset it reads 0x1F00.
- R6: With `rx_dir`=1 and count > high-water level, `rx_dma_req` is high if receive DMA is enabled; otherwise `stat_rx_flag` is high. Both are low when the condition is false.
- R7: With `rx_dir`=0 and count < low-water level, `tx_dma_req` is high if transmit DMA is enabled; otherwise `stat_tx_flag` is high. Both are low when the condition is false.
- R8: The receive condition is ignored when `rx_dir`=0, and the transmit condition is ignored when `rx_dir`=1.
- R9: With `xfer_active`=0 and an empty buffer, all four request and flag outputs are low.
- R10: After a configuration write that sets a DMA enable, the matching status flag is low in the next cycle. Request and flag outputs follow the registered count and configuration, so they reflect a push, pop or write one cycle after its clock edge.
- R11: The processor has priority on each side. `card_push_ready` is low while `cpu_push_valid` is high, and `card_pop_valid` is low while `cpu_pop_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_push_valid | input | 1 | Processor offers a word |
| cpu_push_ready | output | 1 | Buffer can accept a word |
| cpu_push_data | input | 16 | Processor write word |
| cpu_pop_req | input | 1 | Processor read request |
| cpu_pop_data | output | 16 | Head word |
| card_push_valid | input | 1 | Card side offers a word |
| card_push_ready | output | 1 | Card push accepted this cycle |
| card_push_data | input | 16 | Card side word |
| card_pop_valid | output | 1 | Head word available to the card side |
| card_pop_ready | input | 1 | Card side takes the head word |
| card_pop_data | output | 16 | Head word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration readback |
| rx_dir | input | 1 | 1 = receive, 0 = transmit |
| xfer_active | input | 1 | A transfer is in progress |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| stat_rx_flag | output | 1 | Receive high-water status flag |
| stat_tx_flag | output | 1 | Transmit low-water status flag |

## Verification
The bench targets the following corners:

- **Threshold edges.** It tests the count one below, at and one above each threshold. A strict-versus-inclusive comparison mistake would raise a request one word early or late.
- **Full and empty limits.** It writes into a full buffer and reads from an empty one. A design that let these through would corrupt the head word or make the count wrap.
- **Push and pop together.** It pushes and pops in the same cycle. A design that got this wrong would drift the count and move the low-water flag.
- **Enable and direction changes.** It sets a DMA enable while a flag is up, and it flips direction with the buffer above the high-water level. Here a wrong design leaves a stale flag or raises a request for the idle direction.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  localparam int CFG_W       = 16;
  localparam int RX_EN_BIT   = 15;
  localparam int HIGH_LSB    = 8;
  localparam int TX_EN_BIT   = 7;
  localparam int LOW_LSB     = 0;
  localparam int FIELD_MAX_W = 7;
endpackage

// File: rtl/tfifo_ring.sv
module tfifo_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_fire, pop_fire;

  assign full      = (count == FULL_CNT);
  assign empty     = (count == '0);
  assign push_fire = push_req && !full;
  assign pop_fire  = pop_req && !empty;
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
      if (pop_fire)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
      unique case ({push_fire, pop_fire})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_req) |=> (full && $stable(wr_ptr)));
  p_empty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req) |=> (empty && $stable(rd_ptr)));
  p_both_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !empty && !full) |=> $stable(count));
endmodule

// File: rtl/tfifo_cfg.sv
module tfifo_cfg
  import tfifo_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             rx_en,
  output logic [LVL_W-1:0] high_lvl,
  output logic             tx_en,
  output logic [LVL_W-1:0] low_lvl,
  output logic [CFG_W-1:0] cfg_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      high_lvl <= '1;
      low_lvl  <= '0;
    end else if (cfg_wr) begin
      rx_en    <= cfg_wdata[RX_EN_BIT];
      tx_en    <= cfg_wdata[TX_EN_BIT];
      high_lvl <= cfg_wdata[HIGH_LSB +: LVL_W];
      low_lvl  <= cfg_wdata[LOW_LSB +: LVL_W];
    end
  end

  always_comb begin
    cfg_rdata                     = '0;
    cfg_rdata[RX_EN_BIT]          = rx_en;
    cfg_rdata[TX_EN_BIT]          = tx_en;
    cfg_rdata[HIGH_LSB +: LVL_W]  = high_lvl;
    cfg_rdata[LOW_LSB +: LVL_W]   = low_lvl;
  end

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));
endmodule

// File: rtl/tfifo_level.sv
module tfifo_level #(
  parameter int LVL_W = 5,
  parameter int CNT_W = LVL_W + 1
) (
  input  logic [CNT_W-1:0] count,
  input  logic [LVL_W-1:0] high_lvl,
  input  logic [LVL_W-1:0] low_lvl,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             rx_dir,
  input  logic             xfer_active,
  output logic             rx_dma_req,
  output logic             tx_dma_req,
  output logic             stat_rx_flag,
  output logic             stat_tx_flag
);
  logic idle_empty, rx_hit, tx_hit;

  assign idle_empty = !xfer_active && (count == '0);
  assign rx_hit = !idle_empty && rx_dir  && (count > CNT_W'(high_lvl));
  assign tx_hit = !idle_empty && !rx_dir && (count < CNT_W'(low_lvl));

  assign rx_dma_req   = rx_hit && rx_en;
  assign stat_rx_flag = rx_hit && !rx_en;
  assign tx_dma_req   = tx_hit && tx_en;
  assign stat_tx_flag = tx_hit && !tx_en;
endmodule

// File: rtl/thresh_fifo_dma.sv
module thresh_fifo_dma
  import tfifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_push_valid,
  output logic              cpu_push_ready,
  input  logic [DATA_W-1:0] cpu_push_data,
  input  logic              cpu_pop_req,
  output logic [DATA_W-1:0] cpu_pop_data,
  input  logic              card_push_valid,
  output logic              card_push_ready,
  input  logic [DATA_W-1:0] card_push_data,
  output logic              card_pop_valid,
  input  logic              card_pop_ready,
  output logic [DATA_W-1:0] card_pop_data,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              rx_dir,
  input  logic              xfer_active,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic              stat_rx_flag,
  output logic              stat_tx_flag
);
  localparam int LVL_W = $clog2(DEPTH);
  localparam int CNT_W = LVL_W + 1;

  logic              push_req, pop_req, full, empty;
  logic [DATA_W-1:0] push_data, head_data;
  logic [CNT_W-1:0]  count;
  logic              rx_en, tx_en;
  logic [LVL_W-1:0]  high_lvl, low_lvl;

  assign push_req  = cpu_push_valid || card_push_valid;
  assign push_data = cpu_push_valid ? cpu_push_data : card_push_data;
  assign pop_req   = cpu_pop_req || card_pop_ready;

  assign cpu_push_ready  = !full;
  assign card_push_ready = !full && !cpu_push_valid;
  assign card_pop_valid  = !empty && !cpu_pop_req;
  assign cpu_pop_data    = head_data;
  assign card_pop_data   = head_data;

  tfifo_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(LVL_W), .CNT_W(CNT_W)) u_ring (
    .clk, .rst_n, .push_req, .push_data, .pop_req,
    .head_data, .count, .full, .empty
  );

  tfifo_cfg #(.LVL_W(LVL_W)) u_cfg (
    .clk, .rst_n, .cfg_wr, .cfg_wdata,
    .rx_en, .high_lvl, .tx_en, .low_lvl, .cfg_rdata
  );

  tfifo_level #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_level (
    .count, .high_lvl, .low_lvl, .rx_en, .tx_en, .rx_dir, .xfer_active,
    .rx_dma_req, .tx_dma_req, .stat_rx_flag, .stat_tx_flag
  );

  initial begin
    p_field_fits_r5: assert (LVL_W <= FIELD_MAX_W);
  end

  p_enable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[RX_EN_BIT]) |=> !stat_rx_flag);
  p_enable_clears_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[TX_EN_BIT]) |=> !stat_tx_flag);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && empty) |->
      !(rx_dma_req || tx_dma_req || stat_rx_flag || stat_tx_flag));
  p_dir_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dir |-> !(tx_dma_req || stat_tx_flag));
  p_card_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_push_valid |-> !card_push_ready);
endmodule

// File: tb/thresh_fifo_dma_tb.sv
module thresh_fifo_dma_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_push_valid = 0, cpu_pop_req = 0, card_push_valid = 0, card_pop_ready = 0;
  logic cfg_wr = 0, rx_dir = 0, xfer_active = 0;
  logic [15:0] cpu_push_data = 0, card_push_data = 0, cfg_wdata = 0;
  logic cpu_push_ready, card_push_ready, card_pop_valid;
  logic [15:0] cpu_pop_data, card_pop_data, cfg_rdata;
  logic rx_dma_req, tx_dma_req, stat_rx_flag, stat_tx_flag;

  int checks = 0, errors = 0, cyc = 0;

  // model state
  logic [15:0] m_mem [32];
  bit          m_wrt [32];
  int m_head = 0, m_cnt = 0;
  bit m_rxen = 0, m_txen = 0;
  int m_high = 31, m_low = 0;

  always #4 clk = ~clk;

  thresh_fifo_dma u_dut (
    .clk, .rst_n, .cpu_push_valid, .cpu_push_ready, .cpu_push_data,
    .cpu_pop_req, .cpu_pop_data, .card_push_valid, .card_push_ready,
    .card_push_data, .card_pop_valid, .card_pop_ready, .card_pop_data,
    .cfg_wr, .cfg_wdata, .cfg_rdata, .rx_dir, .xfer_active,
    .rx_dma_req, .tx_dma_req, .stat_rx_flag, .stat_tx_flag
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, string name, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: act=%h exp=%h", tag, name, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cfg();
    return {m_rxen, 2'b00, 5'(m_high), m_txen, 2'b00, 5'(m_low)};
  endfunction

  function automatic logic [3:0] exp_flags(); // {rx_req, rx_flag, tx_req, tx_flag}
    bit idle, rxh, txh;
    idle = !xfer_active && m_cnt == 0;
    rxh  = !idle && rx_dir  && m_cnt > m_high;
    txh  = !idle && !rx_dir && m_cnt < m_low;
    return {rxh && m_rxen, rxh && !m_rxen, txh && m_txen, txh && !m_txen};
  endfunction

  task automatic check_all(string tag);
    logic [3:0] f;
    f = exp_flags();
    chk(tag, "cpu_push_ready(R2)", 16'(cpu_push_ready), 16'(m_cnt < 32));
    chk(tag, "card_push_ready(R11)", 16'(card_push_ready), 16'(m_cnt < 32 && !cpu_push_valid));
    chk(tag, "card_pop_valid(R3/R11)", 16'(card_pop_valid), 16'(m_cnt > 0 && !cpu_pop_req));
    chk(tag, "cfg_rdata(R5)", cfg_rdata, exp_cfg());
    chk(tag, "rx_dma_req(R6)", 16'(rx_dma_req), 16'(f[3]));
    chk(tag, "stat_rx_flag(R6)", 16'(stat_rx_flag), 16'(f[2]));
    chk(tag, "tx_dma_req(R7)", 16'(tx_dma_req), 16'(f[1]));
    chk(tag, "stat_tx_flag(R7)", 16'(stat_tx_flag), 16'(f[0]));
    if (m_wrt[m_head]) begin
      chk(tag, "cpu_pop_data(R1)", cpu_pop_data, m_mem[m_head]);
      chk(tag, "card_pop_data(R1)", card_pop_data, m_mem[m_head]);
    end
  endtask

  // Inputs set by the caller are sampled at the next edge: check, then update the model.
  task automatic cycle(string tag);
    bit push, pop;
    logic [15:0] d;
    #1;
    check_all(tag);
    push = (cpu_push_valid || card_push_valid) && m_cnt < 32;
    d    = cpu_push_valid ? cpu_push_data : card_push_data;
    pop  = (cpu_pop_req || card_pop_ready) && m_cnt > 0;
    if (push) begin
      m_mem[(m_head + m_cnt) % 32] = d;
      m_wrt[(m_head + m_cnt) % 32] = 1;
    end
    m_cnt = m_cnt + int'(push) - int'(pop);
    if (pop) m_head = (m_head + 1) % 32;
    if (cfg_wr) begin
      m_rxen = cfg_wdata[15]; m_txen = cfg_wdata[7];
      m_high = int'(cfg_wdata[12:8]); m_low = int'(cfg_wdata[4:0]);
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cpu_push_valid = 0; cpu_pop_req = 0; card_push_valid = 0;
    card_pop_ready = 0; cfg_wr = 0;
  endtask

  task automatic write_cfg(logic [15:0] v);
    idle_inputs(); cfg_wr = 1; cfg_wdata = v; cycle("cfgwr"); cfg_wr = 0;
  endtask

  initial begin
    void'($urandom(32'h1357_2468));
    for (int i = 0; i < 32; i++) m_wrt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5 R9: reset values and idle-empty quiet outputs
    chk("R5", "cfg reset", cfg_rdata, 16'h1F00);
    cycle("R9");

    // R6: receive, high-water 3, DMA off -> flag once count reaches 4
    write_cfg(16'h0300);
    rx_dir = 1; xfer_active = 1;
    for (int i = 0; i < 4; i++) begin
      card_push_valid = 1; card_push_data = 16'hA000 + 16'(i); cycle("R6");
    end
    idle_inputs(); cycle("R6");
    chk("R6", "stat_rx_flag at count 4", 16'(stat_rx_flag), 16'd1);
    // R10: enabling RX DMA drops the flag next cycle and raises the request
    write_cfg(16'h8300);
    cycle("R10");
    chk("R10", "stat_rx_flag after enable", 16'(stat_rx_flag), 16'd0);
    chk("R10", "rx_dma_req after enable", 16'(rx_dma_req), 16'd1);
    // R8: transmit direction ignores the receive condition
    rx_dir = 0; cycle("R8");
    chk("R8", "rx_dma_req in tx dir", 16'(rx_dma_req), 16'd0);

    // R7 / R4: low-water 6, count 4 -> 5, then simultaneous push+pop
    write_cfg(16'h0006);
    cpu_push_valid = 1; cpu_push_data = 16'hB000; cycle("R7");
    card_pop_ready = 1; cpu_push_data = 16'hB001; cycle("R4");
    idle_inputs(); cycle("R4");
    chk("R4", "stat_tx_flag count stays 5", 16'(stat_tx_flag), 16'd1);
    cpu_push_valid = 1; cpu_push_data = 16'hB002; cycle("R7");
    idle_inputs(); cycle("R7");
    chk("R7", "stat_tx_flag at count 6", 16'(stat_tx_flag), 16'd0);

    // R3: drain then pop while empty
    while (m_cnt > 0) begin cpu_pop_req = 1; cycle("R1"); end
    cpu_pop_req = 1; cycle("R3");
    cpu_pop_req = 1; cycle("R3");
    idle_inputs(); cycle("R3");
    chk("R3", "card_pop_valid empty", 16'(card_pop_valid), 16'd0);

    // R2: overfill then R1 order through wrap
    for (int i = 0; i < 34; i++) begin
      cpu_push_valid = 1; cpu_push_data = 16'hC000 + 16'(i); cycle("R2");
    end
    idle_inputs(); cycle("R2");
    chk("R2", "cpu_push_ready full", 16'(cpu_push_ready), 16'd0);
    for (int i = 0; i < 32; i++) begin
      chk("R1", "order", cpu_pop_data, 16'hC000 + 16'(i));
      cpu_pop_req = 1; cycle("R1");
    end
    idle_inputs();
    xfer_active = 0; cycle("R9");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int bias;
      if (n % 250 == 0) begin rx_dir = 1'($urandom); xfer_active = ($urandom % 4) != 0; end
      bias = rx_dir ? 60 : 40;
      cpu_push_valid  = ($urandom % 100) < (100 - bias) / 2;
      cpu_push_data   = 16'($urandom);
      card_push_valid = ($urandom % 100) < (100 - bias) / 2;
      card_push_data  = 16'($urandom);
      cpu_pop_req     = ($urandom % 100) < bias / 2;
      card_pop_ready  = ($urandom % 100) < bias / 2;
      cfg_wr          = ($urandom % 60) == 0;
      cfg_wdata       = 16'($urandom);
      cycle("RND");
    end
    idle_inputs(); cycle("RND");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule